// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two 64-bit unsigned operands and a carry input in a single combinational pass. The operands are cut into four 16-bit groups, and each group is cut again into four 4-bit cells. Every carry is produced in expanded sum-of-products form:

- Inside each cell, the bit carries come from the per-bit generate and propagate terms.
- Inside each group, the cell carries come from the cell generate and propagate terms.
- Across the groups, a second lookahead level forms each group's carry-in from `cin` and the group generate and propagate terms. No group waits for the group below it to produce its carry-out.

The block also drives a block-wide generate flag and a block-wide propagate flag. A further lookahead level can consume these to build a wider adder from several copies of this block, without adding a ripple path. The block has no clock and no storage.

Top module: `cla2_adder`

## Requirements
- R1: `sum` equals the low 64 bits of the unsigned sum a + b + cin for every operand pattern.
- R2: `cout` equals bit 64 (the 65th bit) of the unsigned sum a + b + cin.
- R3: `grp_prop` is 1 exactly when every bit position has a differing pair of operand bits (a ^ b is all ones).
- R4: `grp_gen` is 1 exactly when a + b with a carry input of 0 already produces a carry out of bit 63.
- R5: `cout` always equals grp_gen | (grp_prop & cin), so a higher lookahead level can rebuild the carry-out from the two flags.
- R6: The carry entering each 16-bit group (bit positions 16, 32 and 48) is the carry of a plain binary addition of the bits below it. This holds even when a carry starting at bit 0 must cross every group boundary.
- R7: `grp_gen` and `grp_prop` are never 1 together.
- R8: With a and b forming a full propagate chain (a ^ b all ones, a & b all zeros) and cin = 1, `sum` is all zeros and `cout` is 1. With cin = 0 the same operands give `sum` all ones and `cout` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First unsigned operand |
| b | input | 64 | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 63 |
| grp_gen | output | 1 | Block-wide generate flag, for cascading |
| grp_prop | output | 1 | Block-wide propagate flag, for cascading |

## Verification
The bench builds the adder with its default parameters: 4-bit cells, four cells per group and four groups, for 64 bits in all. With these values, every cell-boundary and group-boundary carry can be reached from directed operands. One set of operands launches a carry at bit 0 and carries it through all three group boundaries. Other sets start a carry just below a single boundary, or make it stop exactly at one. The block-wide flags are driven into each of their three legal combinations and compared with a reference computed from the 65-bit sum.

// File: rtl/cla2_adder.sv
module cla2_adder #(
  parameter int CELL_W = 4,
  parameter int CELLS  = 4,
  parameter int GROUPS = 4
) (
  input  logic [CELL_W*CELLS*GROUPS-1:0] a,
  input  logic [CELL_W*CELLS*GROUPS-1:0] b,
  input  logic                           cin,
  output logic [CELL_W*CELLS*GROUPS-1:0] sum,
  output logic                           cout,
  output logic                           grp_gen,
  output logic                           grp_prop
);
  localparam int GW   = CELL_W * CELLS;
  localparam int W    = GW * GROUPS;
  localparam int NC   = CELLS * GROUPS;
  localparam int M1   = (CELL_W > CELLS) ? CELL_W : CELLS;
  localparam int MAXN = ((M1 > GROUPS) ? M1 : GROUPS) + 1;

  // carry into position k of a lookahead span, fully expanded
  function automatic logic la(input logic [MAXN-1:0] g, input logic [MAXN-1:0] p,
                              input logic ci, input int k);
    logic r, prod;
    r = 1'b0;
    for (int j = -1; j < k; j++) begin
      prod = (j < 0) ? ci : g[j];
      for (int m = j + 1; m < k; m++) prod = prod & p[m];
      r = r | prod;
    end
    return r;
  endfunction

  logic [W-1:0]      g, p, c;
  logic [NC-1:0]     cg, cp, cc;
  logic [GROUPS-1:0] gg, gp;
  logic [GROUPS:0]   gc;

  assign g = a & b;
  assign p = a ^ b;

  always_comb begin
    logic [MAXN-1:0] tg, tp;
    for (int n = 0; n < NC; n++) begin
      tg = '0; tp = '0;
      tg[CELL_W-1:0] = g[n*CELL_W +: CELL_W];
      tp[CELL_W-1:0] = p[n*CELL_W +: CELL_W];
      cg[n] = la(tg, tp, 1'b0, CELL_W);
      cp[n] = &tp[CELL_W-1:0];
    end
    for (int k = 0; k < GROUPS; k++) begin
      tg = '0; tp = '0;
      tg[CELLS-1:0] = cg[k*CELLS +: CELLS];
      tp[CELLS-1:0] = cp[k*CELLS +: CELLS];
      gg[k] = la(tg, tp, 1'b0, CELLS);
      gp[k] = &tp[CELLS-1:0];
    end
    tg = '0; tp = '0;
    tg[GROUPS-1:0] = gg;
    tp[GROUPS-1:0] = gp;
    for (int k = 0; k <= GROUPS; k++) gc[k] = la(tg, tp, cin, k);
    grp_gen  = la(tg, tp, 1'b0, GROUPS);
    grp_prop = &gp;
    for (int k = 0; k < GROUPS; k++) begin
      tg = '0; tp = '0;
      tg[CELLS-1:0] = cg[k*CELLS +: CELLS];
      tp[CELLS-1:0] = cp[k*CELLS +: CELLS];
      for (int m = 0; m < CELLS; m++) cc[k*CELLS+m] = la(tg, tp, gc[k], m);
    end
    for (int n = 0; n < NC; n++) begin
      tg = '0; tp = '0;
      tg[CELL_W-1:0] = g[n*CELL_W +: CELL_W];
      tp[CELL_W-1:0] = p[n*CELL_W +: CELL_W];
      for (int i = 0; i < CELL_W; i++) c[n*CELL_W+i] = la(tg, tp, cc[n], i);
    end
  end

  assign sum  = p ^ c;
  assign cout = gc[GROUPS];
endmodule

// File: rtl/cla2_adder_chk.sv
module cla2_adder_chk #(
  parameter int W      = 64,
  parameter int GW     = 16,
  parameter int GROUPS = 4
) (
  input logic [W-1:0]    a,
  input logic [W-1:0]    b,
  input logic            cin,
  input logic [W-1:0]    sum,
  input logic            cout,
  input logic            grp_gen,
  input logic            grp_prop,
  input logic [GROUPS:0] gc
);
  logic [W:0]   ref_sum, ref_nc;
  logic [W-1:0] ref_carry;

  always_comb begin
    ref_sum   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    ref_nc    = {1'b0, a} + {1'b0, b};
    ref_carry = a ^ b ^ ref_sum[W-1:0];
    a_r1_sum: assert (sum == ref_sum[W-1:0]);
    a_r2_cout: assert (cout == ref_sum[W]);
    a_r3_prop: assert (grp_prop == &(a ^ b));
    a_r4_gen: assert (grp_gen == ref_nc[W]);
    a_r5_cascade: assert (cout == (grp_gen | (grp_prop & cin)));
    a_r7_flags_exclusive: assert (!(grp_gen && grp_prop));
    for (int k = 1; k < GROUPS; k++)
      a_r6_group_carry: assert (gc[k] == ref_carry[k*GW]);
  end
endmodule

bind cla2_adder cla2_adder_chk #(.W(W), .GW(GW), .GROUPS(GROUPS)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .grp_gen(grp_gen), .grp_prop(grp_prop), .gc(gc)
);

// File: tb/cla2_adder_bench.sv
module cla2_adder_bench;
  localparam int W = 64;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic cin, cout, grp_gen, grp_prop;
  int tests = 0, fails = 0;
  bit done = 0;

  cla2_adder u_cla2_adder (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
                           .grp_gen(grp_gen), .grp_prop(grp_prop));

  task automatic check_vec(input logic [W-1:0] xa, input logic [W-1:0] xb,
                           input logic xc, input string req);
    logic [W:0] exp_s, exp_nc;
    a = xa; b = xb; cin = xc;
    @(negedge clk);
    exp_s  = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
    exp_nc = {1'b0, xa} + {1'b0, xb};
    tests++;
    if ({cout, sum} !== exp_s) begin
      fails++;
      $display("FAIL %s R1/R2 sum: got %h_%h expected %h_%h", req, cout, sum, exp_s[W], exp_s[W-1:0]);
    end
    tests++;
    if (grp_prop !== &(xa ^ xb) || grp_gen !== exp_nc[W]) begin
      fails++;
      $display("FAIL %s R3/R4 flags: got gen=%b prop=%b expected gen=%b prop=%b",
               req, grp_gen, grp_prop, exp_nc[W], &(xa ^ xb));
    end
    tests++;
    if (cout !== (grp_gen | (grp_prop & xc)) || (grp_gen & grp_prop) !== 1'b0) begin
      fails++;
      $display("FAIL %s R5/R7 cascade: got cout=%b gen=%b prop=%b expected cout=%b, flags exclusive",
               req, cout, grp_gen, grp_prop, exp_s[W]);
    end
  endtask

  task automatic test_zero();
    check_vec('0, '0, 1'b0, "R1 zeros");
    check_vec('0, '0, 1'b1, "R1 zeros cin");
  endtask

  task automatic test_all_ones();
    check_vec('1, '1, 1'b1, "R2 all ones cin");
    check_vec('1, '1, 1'b0, "R4 all ones");
  endtask

  task automatic test_propagate_chain();
    logic [W-1:0] pat = {(W/2){2'b10}};
    check_vec(pat, ~pat, 1'b1, "R8 chain cin=1");
    tests++;
    if (sum !== '0 || cout !== 1'b1) begin
      fails++;
      $display("FAIL R8: got sum=%h cout=%b expected sum=0 cout=1", sum, cout);
    end
    check_vec(pat, ~pat, 1'b0, "R8 chain cin=0");
    tests++;
    if (sum !== '1 || cout !== 1'b0) begin
      fails++;
      $display("FAIL R8: got sum=%h cout=%b expected sum=all ones cout=0", sum, cout);
    end
  endtask

  task automatic test_alternating();
    check_vec({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b0, "R1 alternating");
    check_vec({(W/2){2'b10}}, {(W/2){2'b10}}, 1'b1, "R1 alternating same");
  endtask

  task automatic test_boundaries();
    check_vec('1, 64'd1, 1'b0, "R6 ripple all groups");
    for (int k = 1; k < 4; k++) begin
      check_vec(64'd1 << (16*k - 1), 64'd1 << (16*k - 1), 1'b0, "R6 just below boundary");
      check_vec((64'd1 << (16*k)) - 1, '0, 1'b1, "R6 stop at boundary");
    end
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++)
      check_vec({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    test_zero();
    test_all_ones();
    test_propagate_chain();
    test_alternating();
    test_boundaries();
    test_random();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule